// File: doc/BRIEF.md
# Register-Amount Shifter with Carry Flag

This block shifts or rotates a data word by a count that arrives in a second register-width operand. Four operations are offered: logical left, logical right, arithmetic right and rotate right. The count comes from the low byte of the amount operand, so it can be far larger than the word width. The block also keeps a carry flag register, which takes the last bit shifted out.

A caller presents the operand, the amount and the operation code together with a one-cycle valid strobe. On the next rising clock edge the result and carry registers load. While the strobe is low, both registers keep their contents. The rules for counts of exactly the word width and above it are the heart of the block. A rotate by a non-zero multiple of the word width leaves the data unchanged but still writes the carry.

Top module: `shift_carry_unit`

## Requirements
- R1: Only amount bits [7:0] form the count. Bits [31:8] have no effect on the result or on the carry.
- R2: When the count is 0, for every operation code, the result register loads the operand unchanged and the carry register keeps its previous value.
- R3: Operation code 2'b00 is logical left. For a count n from 1 to 31 the result is the operand shifted left by n and the carry is operand bit 32−n. At 32 the result is 0 and the carry is operand bit 0. Above 32 both the result and the carry are 0.
- R4: Operation code 2'b01 is logical right. For n from 1 to 31 the result is the operand shifted right by n with zero fill and the carry is operand bit n−1. At 32 the result is 0 and the carry is operand bit 31. Above 32 both are 0.
- R5: Operation code 2'b10 is arithmetic right. For n from 1 to 31 the vacated bits take the sign and the carry is operand bit n−1. For n of 32 or more every result bit equals operand bit 31, and so does the carry.
- R6: Operation code 2'b11 is rotate right by r = n mod 32. When r is non-zero the carry is operand bit r−1. When r is 0 and n is non-zero, the result is the operand unchanged and the carry is operand bit 31.
- R7: The result and carry registers update on the clock edge that samples valid_i high. With valid_i low they hold, whatever the other inputs do.
- R8: Synchronous active-low reset clears the result and the carry to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Loads the registers on this edge |
| operand_i | input | 32 | Data word to shift |
| amount_i | input | 32 | Shift amount operand; low byte is the count |
| kind_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| result_o | output | 32 | Registered shifted word |
| carry_o | output | 1 | Registered carry flag |

## Verification
The bench builds the block with its defaults: a 32-bit word and an 8-bit count. With these values every count from 0 to 255 can be reached, which covers counts below the width, exactly at it, just past it, and the rotate multiples 64 to 224 that reduce to zero. Amounts with non-zero upper bits, idle cycles with changing inputs, and zero counts placed after both carry values test the masking and the hold behaviour.

// File: rtl/shc_pkg.sv
// Shared types for the register-amount shifter.
// Assumes a two-bit operation code whose values are decoded by the bench.
package shc_pkg;
    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shk_kind_e;
endpackage

// File: rtl/shc_count_decode.sv
// Count decoder: takes the count from the low bits of the amount operand
// and flags zero, exactly-width and beyond-width counts.
// Assumes DATA_W is a power of two below 2**CNT_W.
module shc_count_decode #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int AMT_W  = 32,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amount_i,
    output logic             count_zero_o,
    output logic             at_width_o,
    output logic             over_width_o,
    output logic [LOG_W-1:0] low_amt_o
);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);

    logic [CNT_W-1:0] count;
    logic             unused_hi;

    // Keep only the count field; the upper bits are ignored on purpose.
    assign count     = amount_i[CNT_W-1:0];
    assign unused_hi = ^amount_i[AMT_W-1:CNT_W];

    // Classify the count against the word width.
    always_comb begin
        count_zero_o = (count == '0);
        at_width_o   = (count == WIDTH_CNT);
        over_width_o = (count > WIDTH_CNT);
        low_amt_o    = count[LOG_W-1:0];
    end
endmodule

// File: rtl/shc_barrel.sv
// Logarithmic barrel: shifts or rotates by an amount below the word width,
// one power-of-two stage per amount bit.
// Assumes amounts of the full width and above are handled by the caller.
module shc_barrel
    import shc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  shk_kind_e         kind_i,
    input  logic [LOG_W-1:0]  amt_i,
    output logic [DATA_W-1:0] shifted_o
);
    logic [LOG_W:0][DATA_W-1:0] stage;
    logic                       sign;

    assign sign     = operand_i[DATA_W-1];
    assign stage[0] = operand_i;

    for (genvar g = 0; g < LOG_W; g++) begin : g_stage
        localparam int STEP = 1 << g;
        logic [DATA_W-1:0] moved;

        // Move the previous stage by this stage's fixed distance.
        always_comb begin
            case (kind_i)
                SHK_LSL: moved = stage[g] << STEP;
                SHK_LSR: moved = stage[g] >> STEP;
                SHK_ASR: moved = {{STEP{sign}}, stage[g][DATA_W-1:STEP]};
                default: moved = {stage[g][STEP-1:0], stage[g][DATA_W-1:STEP]};
            endcase
        end

        assign stage[g+1] = amt_i[g] ? moved : stage[g];
    end

    assign shifted_o = stage[LOG_W];
endmodule

// File: rtl/shc_carry_pick.sv
// Carry selector: picks the last bit shifted out for each operation,
// including the exactly-width and beyond-width cases, and keeps the
// previous carry when the count is zero.
// Assumes DATA_W is a power of two, so a count equal to the width has
// zero low bits.
module shc_carry_pick
    import shc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  shk_kind_e         kind_i,
    input  logic [LOG_W-1:0]  low_amt_i,
    input  logic              count_zero_i,
    input  logic              at_width_i,
    input  logic              over_width_i,
    input  logic              carry_q_i,
    output logic              carry_next_o
);
    logic [LOG_W-1:0] idx_left;
    logic [LOG_W-1:0] idx_right;

    // Tap positions wrap modulo the width: W-n for left, n-1 for right.
    assign idx_left  = LOG_W'(0) - low_amt_i;
    assign idx_right = low_amt_i - LOG_W'(1);

    // Choose the outgoing bit for the current operation and count range.
    always_comb begin
        if (count_zero_i) begin
            carry_next_o = carry_q_i;
        end else begin
            case (kind_i)
                SHK_LSL: carry_next_o = over_width_i ? 1'b0 : operand_i[idx_left];
                SHK_LSR: carry_next_o = over_width_i ? 1'b0 : operand_i[idx_right];
                SHK_ASR: carry_next_o = (at_width_i || over_width_i)
                                        ? operand_i[DATA_W-1] : operand_i[idx_right];
                default: carry_next_o = operand_i[idx_right];
            endcase
        end
    end
endmodule

// File: rtl/shift_carry_unit.sv
// Register-amount shifter top: decodes the count, runs the barrel and the
// carry selector, resolves the full-width cases and registers the result
// and carry on a valid strobe.
// Assumes a synchronous active-low reset and one operation per strobe.
module shift_carry_unit
    import shc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    localparam int LOG_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] amount_i,
    input  logic [1:0]        kind_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    shk_kind_e         kind;
    logic              count_zero;
    logic              at_width;
    logic              over_width;
    logic [LOG_W-1:0]  low_amt;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] result_next;
    logic              carry_next;
    logic [DATA_W-1:0] result_q;
    logic              carry_q;

    assign kind = shk_kind_e'(kind_i);

    shc_count_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AMT_W(DATA_W)) u_decode (
        .amount_i     (amount_i),
        .count_zero_o (count_zero),
        .at_width_o   (at_width),
        .over_width_o (over_width),
        .low_amt_o    (low_amt)
    );

    shc_barrel #(.DATA_W(DATA_W)) u_barrel (
        .operand_i (operand_i),
        .kind_i    (kind),
        .amt_i     (low_amt),
        .shifted_o (shifted)
    );

    shc_carry_pick #(.DATA_W(DATA_W)) u_carry (
        .operand_i    (operand_i),
        .kind_i       (kind),
        .low_amt_i    (low_amt),
        .count_zero_i (count_zero),
        .at_width_i   (at_width),
        .over_width_i (over_width),
        .carry_q_i    (carry_q),
        .carry_next_o (carry_next)
    );

    // Resolve counts at or beyond the width; rotate always uses the barrel.
    always_comb begin
        result_next = shifted;
        if (!count_zero && (at_width || over_width)) begin
            case (kind)
                SHK_LSL, SHK_LSR: result_next = '0;
                SHK_ASR:          result_next = {DATA_W{operand_i[DATA_W-1]}};
                default:          result_next = shifted;
            endcase
        end
    end

    // Load result and carry on a strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            carry_q  <= 1'b0;
        end else if (valid_i) begin
            result_q <= result_next;
            carry_q  <= carry_next;
        end
    end

    assign result_o = result_q;
    assign carry_o  = carry_q;
endmodule

// File: rtl/shc_checker.sv
// Property checker for the register-amount shifter; attached by bind.
// Assumes the operation code values listed in the package.
module shc_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [DATA_W-1:0] amount_i,
    input logic [1:0]        kind_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o
);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);
    localparam int LOG_W = $clog2(DATA_W);

    logic [CNT_W-1:0] cnt;
    assign cnt = amount_i[CNT_W-1:0];

    // R2: zero count passes the operand and keeps the carry
    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cnt == '0) |=> (result_o == $past(operand_i) && carry_o == $past(carry_o)));

    // R3: left beyond the width clears both outputs
    a_r3_left_beyond: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'b00 && cnt > WIDTH_CNT) |=> (result_o == '0 && !carry_o));

    // R4: logical right at the width keeps the top bit as carry
    a_r4_right_at_width: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'b01 && cnt == WIDTH_CNT)
        |=> (result_o == '0 && carry_o == $past(operand_i[DATA_W-1])));

    // R5: arithmetic right at or beyond the width fills with the sign
    a_r5_arith_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'b10 && cnt >= WIDTH_CNT)
        |=> (result_o == {DATA_W{$past(operand_i[DATA_W-1])}} && carry_o == $past(operand_i[DATA_W-1])));

    // R6: rotate by a non-zero multiple of the width
    a_r6_rotate_multiple: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'b11 && cnt != '0 && cnt[LOG_W-1:0] == '0)
        |=> (result_o == $past(operand_i) && carry_o == $past(operand_i[DATA_W-1])));

    // R7: no strobe, no change
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable(carry_o)));

    // R8: reset clears the registers
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !carry_o));
endmodule

bind shift_carry_unit shc_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .operand_i (operand_i),
    .amount_i  (amount_i),
    .kind_i    (kind_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
);

// File: tb/shift_carry_unit_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the outputs every clock.
module shift_carry_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic [31:0] amount_i = '0;
    logic [1:0]  kind_i = '0;
    logic [31:0] result_o;
    logic        carry_o;

    logic [31:0] exp_res = '0;
    logic        exp_c = 1'b0;
    string       exp_tag = "R8";
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    shift_carry_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .operand_i(operand_i),
        .amount_i(amount_i), .kind_i(kind_i), .result_o(result_o), .carry_o(carry_o)
    );

    // Reference: next result and carry from the requirement text.
    task automatic model(input logic [31:0] op, input logic [31:0] amt,
                         input logic [1:0] k, input logic c_prev,
                         output logic [31:0] r, output logic c, output string tag);
        int n;
        int rr;
        n = amt[7:0];
        case (k)
            2'd0: tag = "R3";
            2'd1: tag = "R4";
            2'd2: tag = "R5";
            default: tag = "R6";
        endcase
        if (n == 0) begin
            r = op; c = c_prev; tag = "R2";
        end else if (k == 2'd0) begin
            if (n < 32)       begin r = op << n; c = op[32-n]; end
            else if (n == 32) begin r = 0; c = op[0]; end
            else              begin r = 0; c = 0; end
        end else if (k == 2'd1) begin
            if (n < 32)       begin r = op >> n; c = op[n-1]; end
            else if (n == 32) begin r = 0; c = op[31]; end
            else              begin r = 0; c = 0; end
        end else if (k == 2'd2) begin
            if (n < 32) begin r = 32'($signed(op) >>> n); c = op[n-1]; end
            else        begin r = {32{op[31]}}; c = op[31]; end
        end else begin
            rr = n % 32;
            if (rr == 0) begin r = op; c = op[31]; end
            else begin r = (op >> rr) | (op << (32 - rr)); c = op[rr-1]; end
        end
        if (amt[31:8] != 0) tag = {"R1/", tag};
    endtask

    // Compare the outputs with the expectation, away from the rising edge.
    task automatic compare();
        total++;
        if (result_o !== exp_res || carry_o !== exp_c) begin
            bad++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     exp_tag, result_o, carry_o, exp_res, exp_c);
        end
    endtask

    // One cycle: drive at the falling edge, check at the next falling edge.
    task automatic step(input logic rst, input logic v, input logic [31:0] op,
                        input logic [31:0] amt, input logic [1:0] k);
        logic [31:0] r;
        logic        c;
        string       t;
        rst_n = rst; valid_i = v; operand_i = op; amount_i = amt; kind_i = k;
        if (!rst) begin
            exp_res = 0; exp_c = 0; exp_tag = "R8";
        end else if (v) begin
            model(op, amt, k, exp_c, r, c, t);
            exp_res = r; exp_c = c; exp_tag = t;
        end else begin
            exp_tag = "R7";
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        logic [31:0] ops [4];
        int          cnts [13];
        ops = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0001};
        cnts = '{0, 1, 2, 16, 31, 32, 33, 63, 64, 96, 128, 224, 255};
        repeat (3) @(negedge clk);
        compare();                                    // R8 after reset
        step(1, 0, 32'hFFFF_FFFF, 32'd5, 2'd0);       // R7 idle
        // R3 R4 R5 R6 R2: sweep all codes, operands and boundary counts
        for (int k = 0; k < 4; k++)
            for (int o = 0; o < 4; o++)
                for (int i = 0; i < 13; i++)
                    step(1, 1, ops[o], 32'(cnts[i]), 2'(k));
        // R2: zero count after carry 1 then after carry 0
        step(1, 1, 32'h0000_0001, 32'd1, 2'd1);
        step(1, 1, 32'h1234_5678, 32'd0, 2'd3);
        step(1, 1, 32'h0000_0000, 32'd1, 2'd1);
        step(1, 1, 32'hFFFF_FFFF, 32'd0, 2'd2);
        // R1: upper amount bits set, including a byte that is zero
        step(1, 1, 32'hC000_0003, 32'hDEAD_BE00, 2'd0);
        step(1, 1, 32'hC000_0003, 32'hFFFF_FF20, 2'd1);
        step(1, 1, 32'hC000_0003, 32'h0000_0121, 2'd0);
        step(1, 1, 32'hC000_0003, 32'h8000_0140, 2'd3);
        // R7: inputs wiggle with no strobe
        for (int i = 0; i < 8; i++)
            step(1, 0, $urandom, $urandom, 2'($urandom));
        // R8: reset in mid-run with a strobe present
        step(0, 1, 32'hFFFF_FFFF, 32'd3, 2'd3);
        step(1, 0, 32'h0, 32'h0, 2'd0);
        // Mixed random traffic over all rules
        for (int i = 0; i < 600; i++)
            step(1, ($urandom % 4) != 0, $urandom, $urandom, 2'($urandom));
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule